// File: doc/BRIEF.md
# ADC Controller Register Bank

This block is the register front end of a twelve-channel successive-approximation converter. Software reaches it over a plain 32-bit register bus with a select, a write flag, an 8-bit byte offset and combinational read data. Through it software sets the converter's mode word and picks which channels take part in a scan. It decides which channels may raise the interrupt, pairs neighbouring channels for signed differential results, starts a scan and reads back the per-channel results.

A start command walks through the enabled channels from the lowest number upward. For each one it sends a single request to an external analog core and waits for that core's done pulse. The 12-bit value is stored in that channel's result slot and the channel's completion flag is raised. The interrupt line is high whenever a raised completion flag is also unmasked. Reading a channel's result slot drops its flag. Channel and interrupt selection each use a pair of write-only registers, one that sets bits and one that clears them, with a separate read-only view of the resulting bits.

Top module: `adcRegBank`

## Requirements
- R1: Writing a 1 to bit 0 of the command register (offset 0x00) returns the mode, channel, mask, pairing, completion, result and last-result state to zero and abandons any scan in progress. This takes effect at the next clock edge, and it wins over a start requested in the same word.
- R2: The mode register at 0x04 keeps only bits 3:1, 5, 6, 15:8, 19:16, 23, 27:24, 29:28 and 31 of a write (mask 0xBF8FFF6E). Its other bits read as zero.
- R3: A write to 0x10 sets the channel-select bits where the data has 1s, and a write to 0x14 clears them. Zero data bits and bits above 11 change nothing. The selected set reads back at 0x18, bit n for channel n.
- R4: A write to 0x24 sets and a write to 0x28 clears bits of the interrupt mask, with the same bit-per-channel rules as R3. The mask reads back at 0x2C.
- R5: Writing a 1 to bit 1 of 0x00 while no scan runs starts one request (anaStart high for one cycle, with anaChan) per selected channel, in strictly ascending channel order, each after the previous done pulse. A start while a scan runs, or with no channel selected, issues no request.
- R6: A done pulse for channel n stores anaData as its result and sets bit n of the completion flags read at 0x30. A read of that channel's result clears the bit. If the read and the completion fall in the same cycle, the bit stays set.
- R7: irq is high exactly while some completion flag is set whose mask bit is also set.
- R8: The pairing register at 0x4C keeps bits 27:16 and reads other bits as zero. Bit 16+n marks channel n as part of a signed pair. Channel n's result reads at 0x50+4n: sign-extended from bit 11 when its pairing bit is set, otherwise zero-extended, judged at read time.
- R9: Offset 0x20 returns the most recently stored result, extended by the pairing bit of the channel that produced it.
- R10: Offset 0xFC reads the fixed identifier 0x00000A51. Any other offset outside the mapped set reads zero, including the write-only registers at 0x00, 0x10, 0x14, 0x24 and 0x28. Writes to an unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 write, 0 read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| irq | output | 1 | Interrupt request, high while any unmasked completion is pending |
| anaStart | output | 1 | One-cycle conversion request to the analog core |
| anaChan | output | 4 | Channel of the current request |
| anaDone | input | 1 | One-cycle completion from the analog core |
| anaData | input | 12 | Conversion value, valid with anaDone |

## Verification
One clash is possible: a channel's completion arriving in the same clock cycle as a software read of that channel's result slot, where one sets the flag and the other clears it. The bench takes the analog done line under direct control while a scan waits on channel 4. It raises done with a fresh value in the same cycle as the bus read of offset 0x60. The read must return the previous value, the completion bit must remain set, and a second read must return the fresh value and then clear the bit.

// File: rtl/adcRegPkg.sv
package adcRegPkg;
  localparam int ADDR_W     = 8;
  localparam int BUS_W      = 32;
  localparam int CHAN_N     = 12;
  localparam int CHAN_IDX_W = $clog2(CHAN_N);
  localparam int RES_W      = 12;
  localparam int DIFF_LSB   = 16;

  localparam logic [ADDR_W-1:0] OFF_CMD     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CHSET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CHCLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CHVIEW  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_LAST    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_INTSET  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_INTCLR  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_INTVIEW = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_DONE    = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_PAIR    = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_DATA0   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_ID      = 8'hFC;

  localparam logic [BUS_W-1:0] MODE_KEEP = 32'hBF8F_FF6E;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seqState_t;

  typedef struct packed {
    logic                  swReset;
    logic                  modeWr;
    logic                  chSet;
    logic                  chClr;
    logic                  intSet;
    logic                  intClr;
    logic                  pairWr;
    logic                  dataHit;
    logic                  dataRd;
    logic [CHAN_IDX_W-1:0] dataIdx;
    logic                  capValid;
    logic [CHAN_IDX_W-1:0] capChan;
  } regStrobe_t;
endpackage

// File: rtl/adcRegCtrl.sv
module adcRegCtrl
  import adcRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            cmdBits,
  input  logic [CHAN_N-1:0]     chanEn,
  input  logic                  anaDone,
  output regStrobe_t            strobe,
  output logic                  anaStart,
  output logic [CHAN_IDX_W-1:0] anaChan
);
  logic wrEn, rdEn, cmdHit, swReset, startReq;
  logic [ADDR_W-1:0] dataOff;
  logic inDataWin;

  seqState_t state;
  logic [CHAN_N-1:0] pend, pendNext;
  logic [CHAN_IDX_W-1:0] curChan;
  logic capValid;

  function automatic logic [CHAN_IDX_W-1:0] lowestSet(input logic [CHAN_N-1:0] v);
    logic [CHAN_IDX_W-1:0] r;
    r = '0;
    for (int i = CHAN_N - 1; i >= 0; i--) begin
      if (v[i]) r = CHAN_IDX_W'(i);
    end
    return r;
  endfunction

  assign wrEn     = busSel && busWr;
  assign rdEn     = busSel && !busWr;
  assign cmdHit   = wrEn && (busAddr == OFF_CMD);
  assign swReset  = cmdHit && cmdBits[0];
  assign startReq = cmdHit && cmdBits[1] && !cmdBits[0];

  assign dataOff   = busAddr - OFF_DATA0;
  assign inDataWin = (busAddr >= OFF_DATA0) && (dataOff[1:0] == 2'b00) &&
                     ({2'b00, dataOff[ADDR_W-1:2]} < ADDR_W'(CHAN_N));

  assign pendNext = pend & ~(CHAN_N'(1) << curChan);
  assign capValid = (state == SEQ_WAIT) && anaDone && !swReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      pend    <= '0;
      curChan <= '0;
    end else if (swReset) begin
      state   <= SEQ_IDLE;
      pend    <= '0;
      curChan <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (startReq && (chanEn != '0)) begin
            pend    <= chanEn;
            curChan <= lowestSet(chanEn);
            state   <= SEQ_REQ;
          end
        end
        SEQ_REQ: state <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (anaDone) begin
            pend <= pendNext;
            if (pendNext != '0) begin
              curChan <= lowestSet(pendNext);
              state   <= SEQ_REQ;
            end else begin
              state <= SEQ_IDLE;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.swReset  = swReset;
    strobe.modeWr   = wrEn && (busAddr == OFF_MODE);
    strobe.chSet    = wrEn && (busAddr == OFF_CHSET);
    strobe.chClr    = wrEn && (busAddr == OFF_CHCLR);
    strobe.intSet   = wrEn && (busAddr == OFF_INTSET);
    strobe.intClr   = wrEn && (busAddr == OFF_INTCLR);
    strobe.pairWr   = wrEn && (busAddr == OFF_PAIR);
    strobe.dataHit  = inDataWin;
    strobe.dataRd   = inDataWin && rdEn;
    strobe.dataIdx  = dataOff[2 +: CHAN_IDX_W];
    strobe.capValid = capValid;
    strobe.capChan  = curChan;
  end

  assign anaStart = (state == SEQ_REQ);
  assign anaChan  = curChan;

  // R5
  seq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anaStart |=> !anaStart);

  // R5
  seq_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && (pendNext != '0)) |=> (anaStart && (anaChan > $past(anaChan))));

  // R5
  seq_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && !startReq) |=> !anaStart);

  // R1
  seq_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (!anaStart && state == SEQ_IDLE));
endmodule

// File: rtl/adcRegData.sv
module adcRegData
  import adcRegPkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h0000_0A51
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [RES_W-1:0]  anaData,
  output logic [BUS_W-1:0]  busRdata,
  output logic [CHAN_N-1:0] chanEn,
  output logic              irq
);
  logic [BUS_W-1:0]      modeReg;
  logic [CHAN_N-1:0]     intMask;
  logic [CHAN_N-1:0]     pairSel;
  logic [CHAN_N-1:0]     doneStat;
  logic [RES_W-1:0]      results [CHAN_N];
  logic [RES_W-1:0]      lastData;
  logic [CHAN_IDX_W-1:0] lastChan;
  logic [CHAN_N-1:0]     wrBits;

  assign wrBits = busWdata[CHAN_N-1:0];

  function automatic logic [BUS_W-1:0] widen(input logic [RES_W-1:0] v, input logic sgn);
    return sgn ? {{(BUS_W-RES_W){v[RES_W-1]}}, v} : {{(BUS_W-RES_W){1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      chanEn  <= '0;
      intMask <= '0;
      pairSel <= '0;
    end else if (st.swReset) begin
      modeReg <= '0;
      chanEn  <= '0;
      intMask <= '0;
      pairSel <= '0;
    end else begin
      if (st.modeWr) modeReg <= busWdata & MODE_KEEP;
      if (st.chSet)  chanEn  <= chanEn | wrBits;
      if (st.chClr)  chanEn  <= chanEn & ~wrBits;
      if (st.intSet) intMask <= intMask | wrBits;
      if (st.intClr) intMask <= intMask & ~wrBits;
      if (st.pairWr) pairSel <= busWdata[DIFF_LSB +: CHAN_N];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneStat <= '0;
      lastData <= '0;
      lastChan <= '0;
    end else if (st.swReset) begin
      doneStat <= '0;
      lastData <= '0;
      lastChan <= '0;
    end else begin
      for (int i = 0; i < CHAN_N; i++) begin
        if (st.capValid && st.capChan == CHAN_IDX_W'(i))
          doneStat[i] <= 1'b1;
        else if (st.dataRd && st.dataIdx == CHAN_IDX_W'(i))
          doneStat[i] <= 1'b0;
      end
      if (st.capValid) begin
        lastData <= anaData;
        lastChan <= st.capChan;
      end
    end
  end

  for (genvar g = 0; g < CHAN_N; g++) begin : gResult
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        results[g] <= '0;
      else if (st.swReset)
        results[g] <= '0;
      else if (st.capValid && st.capChan == CHAN_IDX_W'(g))
        results[g] <= anaData;
    end
  end

  always_comb begin
    busRdata = '0;
    if (st.dataHit) begin
      busRdata = widen(results[st.dataIdx], pairSel[st.dataIdx]);
    end else begin
      case (busAddr)
        OFF_MODE:    busRdata = modeReg;
        OFF_CHVIEW:  busRdata = BUS_W'(chanEn);
        OFF_LAST:    busRdata = widen(lastData, pairSel[lastChan]);
        OFF_INTVIEW: busRdata = BUS_W'(intMask);
        OFF_DONE:    busRdata = BUS_W'(doneStat);
        OFF_PAIR:    busRdata = BUS_W'(pairSel) << DIFF_LSB;
        OFF_ID:      busRdata = VERSION_ID;
        default:     busRdata = '0;
      endcase
    end
  end

  assign irq = |(doneStat & intMask);

  // R7
  irq_on_masked_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.capValid && intMask[st.capChan] && !st.intClr) |=> irq);

  // R6
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capValid |=> doneStat[$past(st.capChan)]);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.dataRd && !(st.capValid && st.capChan == st.dataIdx)) |=> !doneStat[$past(st.dataIdx)]);

  // R3
  chan_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.chSet |=> ((chanEn & $past(wrBits)) == $past(wrBits)));

  // R3
  chan_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.chClr |=> ((chanEn & $past(wrBits)) == '0));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.intClr |=> ((intMask & $past(wrBits)) == '0));

  // R1
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.swReset |=> (chanEn == '0 && intMask == '0 && doneStat == '0 && modeReg == '0 && !irq));
endmodule

// File: rtl/adcRegBank.sv
module adcRegBank
  import adcRegPkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h0000_0A51
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BUS_W-1:0]      busWdata,
  output logic [BUS_W-1:0]      busRdata,
  output logic                  irq,
  output logic                  anaStart,
  output logic [CHAN_IDX_W-1:0] anaChan,
  input  logic                  anaDone,
  input  logic [RES_W-1:0]      anaData
);
  regStrobe_t        strobe;
  logic [CHAN_N-1:0] chanEn;

  adcRegCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .cmdBits  (busWdata[1:0]),
    .chanEn   (chanEn),
    .anaDone  (anaDone),
    .strobe   (strobe),
    .anaStart (anaStart),
    .anaChan  (anaChan)
  );

  adcRegData #(.VERSION_ID(VERSION_ID)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .anaData  (anaData),
    .busRdata (busRdata),
    .chanEn   (chanEn),
    .irq      (irq)
  );
endmodule

// File: tb/adcRegBank_test.sv
`timescale 1ns/1ps
module adcRegBank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic        anaStart;
  logic [3:0]  anaChan;
  logic        anaDone;
  logic [11:0] anaData;

  logic        manual = 1'b0;
  logic        manDone = 1'b0;
  logic [11:0] manData = '0;
  logic        autoDone = 1'b0;
  logic [11:0] autoData = '0;

  int errors = 0;
  int checks = 0;
  int reqCount = 0;
  int doneCount = 0;
  int delay = 0;
  logic [3:0] reqLog [64];
  logic [3:0] pendChan = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign anaDone = manual ? manDone : autoDone;
  assign anaData = manual ? manData : autoData;

  adcRegBank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .anaStart(anaStart),
    .anaChan(anaChan), .anaDone(anaDone), .anaData(anaData)
  );

  function automatic logic [11:0] modelVal(input int c);
    logic [11:0] v;
    v = 12'(c) * 12'h151 + 12'h8C3;
    return v;
  endfunction

  function automatic logic [31:0] sx(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  // analog core stand-in, three cycles of latency
  always @(negedge clk) begin
    autoDone <= 1'b0;
    if (anaStart) begin
      if (reqCount < 64) reqLog[reqCount] = anaChan;
      reqCount = reqCount + 1;
      pendChan = anaChan;
      if (!manual) delay = 3;
    end else if (delay > 0) begin
      delay = delay - 1;
      if (delay == 0) begin
        autoDone <= 1'b1;
        autoData <= modelVal(int'(pendChan));
        doneCount = doneCount + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic waitDone(input int target);
    for (int i = 0; i < 400; i++) begin
      if (doneCount >= target) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    rdCheck("R1 reset mode", 8'h04, 32'h0);
    rdCheck("R3 reset chan view", 8'h18, 32'h0);
    rdCheck("R4 reset mask view", 8'h2C, 32'h0);
    rdCheck("R6 reset done flags", 8'h30, 32'h0);
    #1 check("R7 reset irq", {31'b0, irq}, 32'h0);
    rdCheck("R10 id", 8'hFC, 32'h0000_0A51);
  endtask

  task automatic tMode();
    wr(8'h04, 32'hFFFF_FFFF);
    rdCheck("R2 mode all ones", 8'h04, 32'hBF8F_FF6E);
    wr(8'h04, 32'h1234_5678);
    rdCheck("R2 mode pattern", 8'h04, 32'h1234_5678 & 32'hBF8F_FF6E);
  endtask

  task automatic tChan();
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h005);
    rdCheck("R3 set", 8'h18, 32'h005);
    wr(8'h10, 32'h0A0);
    rdCheck("R3 set accumulates", 8'h18, 32'h0A5);
    wr(8'h14, 32'h004);
    rdCheck("R3 clear", 8'h18, 32'h0A1);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    rdCheck("R3 zero bits no effect", 8'h18, 32'h0A1);
    wr(8'h10, 32'hFFFF_F000);
    rdCheck("R3 upper bits ignored", 8'h18, 32'h0A1);
    wr(8'h24, 32'h812);
    rdCheck("R4 mask set", 8'h2C, 32'h812);
    wr(8'h28, 32'h802);
    rdCheck("R4 mask clear", 8'h2C, 32'h010);
    wr(8'h28, 32'h0);
    rdCheck("R4 zero bits no effect", 8'h2C, 32'h010);
  endtask

  task automatic tUnmapped();
    wr(8'h00, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rdCheck("R10 unmapped write mode", 8'h04, 32'h0);
    rdCheck("R10 unmapped write chan", 8'h18, 32'h0);
    rdCheck("R10 unmapped write mask", 8'h2C, 32'h0);
    rdCheck("R10 unmapped write pair", 8'h4C, 32'h0);
    rdCheck("R10 unmapped read 08", 8'h08, 32'h0);
    rdCheck("R10 unmapped read 80", 8'h80, 32'h0);
    rdCheck("R10 set reg reads zero", 8'h10, 32'h0);
    rdCheck("R10 command reads zero", 8'h00, 32'h0);
  endtask

  task automatic tSequence();
    int base, dbase;
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h44A);
    wr(8'h24, 32'h008);
    base = reqCount; dbase = doneCount;
    wr(8'h00, 32'h2);
    waitDone(dbase + 4);
    check("R5 request count", 32'(reqCount - base), 32'd4);
    check("R5 order first", {28'b0, reqLog[base]},     32'd1);
    check("R5 order second", {28'b0, reqLog[base + 1]}, 32'd3);
    check("R5 order third", {28'b0, reqLog[base + 2]}, 32'd6);
    check("R5 order fourth", {28'b0, reqLog[base + 3]}, 32'd10);
    rdCheck("R6 done flags", 8'h30, 32'h44A);
    #1 check("R7 irq with masked done", {31'b0, irq}, 32'h1);
    rdCheck("R9 last result", 8'h20, {20'b0, modelVal(10)});
    rdCheck("R8 ch1 result", 8'h54, {20'b0, modelVal(1)});
    rdCheck("R6 read clears ch1", 8'h30, 32'h448);
    #1 check("R7 irq still high", {31'b0, irq}, 32'h1);
    rdCheck("R8 ch3 result", 8'h5C, {20'b0, modelVal(3)});
    #1 check("R7 irq drops", {31'b0, irq}, 32'h0);
    rdCheck("R6 read clears ch3", 8'h30, 32'h440);
    rdCheck("R10 command self clears", 8'h00, 32'h0);
  endtask

  task automatic tEmptyAndBusy();
    int base, dbase;
    wr(8'h00, 32'h1);
    base = reqCount;
    wr(8'h00, 32'h2);
    idle(20);
    check("R5 no channel no request", 32'(reqCount - base), 32'd0);
    rdCheck("R5 no channel no flag", 8'h30, 32'h0);
    wr(8'h10, 32'h024);
    base = reqCount; dbase = doneCount;
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h2);
    waitDone(dbase + 2);
    idle(30);
    check("R5 start while busy ignored", 32'(reqCount - base), 32'd2);
    rdCheck("R6 busy scan flags", 8'h30, 32'h024);
  endtask

  task automatic tPair();
    int dbase;
    wr(8'h00, 32'h1);
    wr(8'h4C, 32'hFFFF_FFFF);
    rdCheck("R8 pair field width", 8'h4C, 32'h0FFF_0000);
    wr(8'h4C, 32'h0003_0000);
    wr(8'h10, 32'h043);
    dbase = doneCount;
    wr(8'h00, 32'h2);
    waitDone(dbase + 3);
    rdCheck("R8 ch0 signed", 8'h50, sx(modelVal(0)));
    rdCheck("R8 ch1 signed", 8'h54, sx(modelVal(1)));
    rdCheck("R8 ch6 unsigned", 8'h68, {20'b0, modelVal(6)});
    rdCheck("R9 last unsigned", 8'h20, {20'b0, modelVal(6)});
    wr(8'h4C, 32'h0004_0000);
    wr(8'h14, 32'h043);
    wr(8'h10, 32'h004);
    dbase = doneCount;
    wr(8'h00, 32'h2);
    waitDone(dbase + 1);
    rdCheck("R9 last signed", 8'h20, sx(modelVal(2)));
    rdCheck("R8 ch2 signed", 8'h58, sx(modelVal(2)));
    rdCheck("R8 pairing judged at read", 8'h50, {20'b0, modelVal(0)});
  endtask

  task automatic tCollide();
    int dbase;
    logic [31:0] d;
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h010);
    dbase = doneCount;
    wr(8'h00, 32'h2);
    waitDone(dbase + 1);
    rdCheck("R6 ch4 flag before clash", 8'h30, 32'h010);
    manual = 1'b1;
    wr(8'h00, 32'h2);
    idle(4);
    @(negedge clk);
    manDone = 1'b1; manData = 12'h3C7;
    busSel = 1'b1; busWr = 1'b0; busAddr = 8'h60;
    #1 d = busRdata;
    @(negedge clk);
    manDone = 1'b0; busSel = 1'b0;
    check("R6 clash read sees old value", d, {20'b0, modelVal(4)});
    rdCheck("R6 clash completion wins", 8'h30, 32'h010);
    rdCheck("R6 clash new value", 8'h60, 32'h0000_03C7);
    rdCheck("R6 cleared after second read", 8'h30, 32'h0);
    manual = 1'b0;
  endtask

  task automatic tSoftReset();
    int base, dbase;
    wr(8'h00, 32'h1);
    wr(8'h04, 32'h0000_FF00);
    wr(8'h4C, 32'h0001_0000);
    wr(8'h24, 32'h001);
    wr(8'h10, 32'h001);
    dbase = doneCount;
    wr(8'h00, 32'h2);
    waitDone(dbase + 1);
    #1 check("R7 irq before soft reset", {31'b0, irq}, 32'h1);
    base = reqCount;
    wr(8'h00, 32'h3);
    idle(20);
    check("R1 reset beats start", 32'(reqCount - base), 32'd0);
    #1 check("R1 irq cleared", {31'b0, irq}, 32'h0);
    rdCheck("R1 mode cleared", 8'h04, 32'h0);
    rdCheck("R1 chan cleared", 8'h18, 32'h0);
    rdCheck("R1 mask cleared", 8'h2C, 32'h0);
    rdCheck("R1 pair cleared", 8'h4C, 32'h0);
    rdCheck("R1 flags cleared", 8'h30, 32'h0);
    rdCheck("R1 result cleared", 8'h50, 32'h0);
    rdCheck("R1 last cleared", 8'h20, 32'h0);
    wr(8'h10, 32'h180);
    base = reqCount;
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    idle(30);
    check("R1 scan abandoned", 32'(reqCount - base), 32'd1);
    rdCheck("R1 late done ignored", 8'h30, 32'h0);
    rdCheck("R1 late done no last", 8'h20, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    tReset();
    tMode();
    tChan();
    tUnmapped();
    tSequence();
    tEmptyAndBusy();
    tPair();
    tCollide();
    tSoftReset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule